// File: doc/BRIEF.md
# Dual-Control Synchronous Up/Down Counter

This block is a parameterised N-bit synchronous binary counter driven by two separate direction controls. Every bit is a toggle stage. Each stage flips when the bits below it all hold the value that makes a carry or a borrow ripple through: all ones when counting up, all zeros when counting down. Asserting the increment control always makes the counter count up, even when the decrement control is also high. Asserting only the decrement control makes it count down. With neither control asserted, the count holds.

A synchronous active-high clear forces the count to zero and takes priority over both controls. Two terminal-count flags mark the step on which the count wraps, one for each direction. They can be used to chain counters or to detect the end of a period.

Top module: `updn_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the count becomes zero on that edge.
- R2: When `clr` is high (and `rst_n` high) at a rising edge, the count becomes zero, whatever the values of `inc` and `dec`.
- R3: When `inc` is high and `clr` low, the count increases by one modulo 2^W on the edge, regardless of `dec` (up wins the tie).
- R4: When `dec` is high, `inc` low and `clr` low, the count decreases by one modulo 2^W on the edge.
- R5: When `inc`, `dec` and `clr` are all low, the count is unchanged on the edge.
- R6: Counting up from all ones gives zero, and counting down from zero gives all ones.
- R7: `tc_up` is high exactly when `inc` is high, `clr` low and the count is all ones (combinational from the current count and controls).
- R8: `tc_dn` is high exactly when `dec` is high, `inc` low, `clr` low and the count is zero (combinational).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous active-high clear, highest functional priority |
| inc | input | 1 | Count-up request; wins over `dec` |
| dec | input | 1 | Count-down request |
| count | output | W | Current count value |
| tc_up | output | 1 | Up terminal count: counting up from all ones |
| tc_dn | output | 1 | Down terminal count: counting down from zero |

## Verification
A wrong toggle condition in any stage shows up on `count` at the first edge where that stage's lower bits reach the all-ones or all-zeros pattern. For the top bit this is at most 2^(W-1) steps after reset, so the bench runs full sweeps in both directions. A wrong resolution of the control priority appears at the very next edge after the conflicting inputs. A wrong flag decode is visible in the same cycle, without waiting for an edge. The bench compares every port against an integer model after each edge, and the flags before each edge.

// File: rtl/updn_counter_pkg.sv
// Package: shared direction encoding for the up/down counter.
// Assumes: nothing; pure type definitions.
package updn_counter_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD  = 2'd0,
        DIR_UP    = 2'd1,
        DIR_DOWN  = 2'd2,
        DIR_CLEAR = 2'd3
    } dir_e;
endpackage

// File: rtl/updn_dir_ctrl.sv
// Module: updn_dir_ctrl
// Resolves clear, increment and decrement into one direction code.
// Priority: clear > up > down > hold. Assumes inputs are synchronous.
module updn_dir_ctrl
    import updn_counter_pkg::*;
(
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output dir_e dir
);
    // Purpose: priority encode the three controls.
    always_comb begin
        if (clr)      dir = DIR_CLEAR;
        else if (inc) dir = DIR_UP;
        else if (dec) dir = DIR_DOWN;
        else          dir = DIR_HOLD;
    end
endmodule

// File: rtl/updn_toggle_chain.sv
// Module: updn_toggle_chain
// Computes per-bit toggle enables: bit i toggles going up when all lower
// bits are 1, going down when all lower bits are 0. Also gives the
// all-ones / all-zeros detect of the whole word for terminal counts.
// Assumes W >= 1.
module updn_toggle_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] q,
    input  logic         up_en,
    input  logic         dn_en,
    output logic [W-1:0] tgl,
    output logic         all_ones,
    output logic         all_zeros
);
    logic [W:0] ones_below;
    logic [W:0] zeros_below;

    assign ones_below[0]  = 1'b1;
    assign zeros_below[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_stage
        // Purpose: extend the lower-bit AND chains and form the toggle enable.
        assign ones_below[i+1]  = ones_below[i]  &  q[i];
        assign zeros_below[i+1] = zeros_below[i] & ~q[i];
        assign tgl[i] = (up_en & ones_below[i]) | (dn_en & zeros_below[i]);
    end

    assign all_ones  = ones_below[W];
    assign all_zeros = zeros_below[W];
endmodule

// File: rtl/updn_counter.sv
// Module: updn_counter (top)
// W-bit synchronous binary up/down counter built from toggle stages,
// with separate up/down requests (up wins), synchronous clear and
// per-direction terminal-count flags. Synchronous active-low reset.
module updn_counter
    import updn_counter_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         tc_up,
    output logic         tc_dn
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    dir_e         dir;
    logic [W-1:0] q;
    logic [W-1:0] tgl;
    logic         up_en;
    logic         dn_en;
    logic         q_ones;
    logic         q_zeros;

    updn_dir_ctrl u_ctrl (
        .clr (clr),
        .inc (inc),
        .dec (dec),
        .dir (dir)
    );

    assign up_en = (dir == DIR_UP);
    assign dn_en = (dir == DIR_DOWN);

    updn_toggle_chain #(.W(W)) u_chain (
        .q         (q),
        .up_en     (up_en),
        .dn_en     (dn_en),
        .tgl       (tgl),
        .all_ones  (q_ones),
        .all_zeros (q_zeros)
    );

    // Purpose: toggle-stage register with reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= '0;
        else if (dir == DIR_CLEAR) q <= '0;
        else                       q <= q ^ tgl;
    end

    assign count = q;
    assign tc_up = up_en & q_ones;
    assign tc_dn = dn_en & q_zeros;

    // Assertions guarding the register and flags.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0));
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (count == $past(count) + 1'b1));
    assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !clr) |=> (count == $past(count) - 1'b1));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec && !clr) |=> $stable(count));
    assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_up |=> (count == '0));
    assert_wrap_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_dn |=> (count == ALL_ONES));
    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tc_up && tc_dn));
    assert_dnflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_dn |-> (count == '0 && !inc));
endmodule

// File: tb/tb_updn_counter.sv
module tb_updn_counter;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         clr = 0;
    logic         inc = 0;
    logic         dec = 0;
    logic [W-1:0] count;
    logic         tc_up;
    logic         tc_dn;

    int vecs = 0;
    int errs = 0;
    int model = 0;
    int cyc = 0;

    updn_counter #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .dec(dec),
        .count(count), .tc_up(tc_up), .tc_dn(tc_dn)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one cycle of controls, check flags before the edge, update the
    // model at the edge, and check the count after it.
    task automatic step(input logic c, input logic u, input logic d, input string req);
        int eu, ed;
        clr = c; inc = u; dec = d;
        #1;
        eu = (!c && u && model == M-1) ? 1 : 0;
        ed = (!c && !u && d && model == 0) ? 1 : 0;
        if (rst_n) begin
            chk({req, " R7 tc_up"}, int'(tc_up), eu);
            chk({req, " R8 tc_dn"}, int'(tc_dn), ed);
        end
        @(posedge clk);
        if (!rst_n || c) model = 0;
        else if (u)      model = (model + 1) % M;
        else if (d)      model = (model + M - 1) % M;
        @(negedge clk);
        chk({req, " count"}, int'(count), model);
    endtask

    initial begin
        @(negedge clk);
        step(0, 1, 0, "R1 reset");
        rst_n = 1;
        // Full up sweep with wrap.
        for (int i = 0; i < M + 2; i++) step(0, 1, 0, "R3/R6 up");
        // Tie: up wins.
        for (int i = 0; i < 3; i++) step(0, 1, 1, "R3 tie");
        // Hold.
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R5 hold");
        // Clear over up and down.
        step(1, 1, 1, "R2 clear");
        step(1, 0, 1, "R2 clear");
        // Down sweep from zero with wrap.
        for (int i = 0; i < M + 2; i++) step(0, 0, 1, "R4/R6 down");
        // Mixed pattern.
        for (int i = 0; i < 40; i++)
            step((i % 13) == 7, (i % 3) == 0, (i % 2) == 0, "R3/R4/R5 mix");
        // Reset mid-count.
        rst_n = 0;
        step(0, 1, 0, "R1 reset");
        rst_n = 1;
        step(0, 0, 0, "R5 hold after reset");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            errs++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 5000);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule